// File: doc/BRIEF.md
# Idle-Locked Stream Descrambler

This block sits in the receive path of a 100 Mb/s twisted-pair link, after the line decoding has turned the received signal back into a scrambled serial bit stream at 125 Mb/s. It takes one scrambled bit per transfer and returns one plain code bit per transfer. The plain bit is the received bit XORed with a key bit. The key bits come from an 11-stage linear feedback register with feedback polynomial x^11 + x^9 + 1. Each descrambled bit is also shifted into a parallel word, which feeds the symbol aligner downstream.

The block has no fixed seed for its key. While idle code groups are arriving, the transmitted plain bits are all ones, so each received bit, inverted, is a key bit. The block loads eleven such bits as a candidate key and then tests the candidate against further traffic. Once the candidate has predicted a run of bits correctly, the block raises a lock flag. From then on the key runs freely and no longer follows the line. A watchdog then checks that idle runs keep appearing. If none appears within a window long enough for the largest legal frame, the block drops lock, emits a one-cycle abort pulse and starts a new key search.

Both data edges use valid/ready. An input bit transfers when `in_valid` and `out_ready` are both high. `in_ready` follows `out_ready` with no storage in between, and `out_valid` follows `in_valid`. When downstream holds `out_ready` low, the block holds its state and applies back-pressure to the source. `out_bit` is meaningful only while `locked` is high.

Top module: `stream_descrambler`

## Requirements
- R1: A synchronous active-high reset clears `locked`, `abort_pulse` and `out_word` to zero. It leaves the block searching, with the key cleared to zero and the watchdog and run counters at zero.
- R2: For every transfer, `out_bit` equals `in_bit` XOR the current key bit. The key obeys k[n] = k[n-11] XOR k[n-9].
- R3: While unlocked, each transferred bit is inverted and taken as the next key bit. After 11 such bits have been loaded in the search state, the block moves to the checking state.
- R4: In the checking state, each transferred bit whose inverse equals the predicted key bit counts as a match. `locked` rises on the clock edge that takes the CHECK_LEN-th consecutive match (default 30). With the defaults, `locked` is therefore high after 41 idle bits received since the start of a search.
- R5: A mismatch in the checking state returns the block to the search state with a fill count of zero. A full 11-bit load and a fresh match run are then needed before lock.
- R6: Once locked, the key advances by its own recurrence on every transfer, regardless of the line. A stream of idle and data bits scrambled with the same key sequence is returned as the original plain bits.
- R7: While locked, the watchdog counts clock cycles, including cycles with no transfer. It is cleared only by a transferred descrambled one that ends a run of at least 10 consecutive descrambled ones. Runs of nine ones followed by a zero never clear it.
- R8: When the watchdog reaches WD_CYCLES cycles without being cleared, `abort_pulse` is high for exactly one cycle. In that same cycle `locked` is low, and the block restarts the search.
- R9: `in_ready` equals `out_ready` and `out_valid` equals `in_valid`. A cycle with no transfer changes neither the key nor the sync state nor `out_word`.
- R10: On each transfer, `out_word` shifts left by one and takes the descrambled bit into bit 0. Bit WORD_W-1 therefore holds the oldest of the last WORD_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Scrambled bit is present |
| in_ready | output | 1 | Block can take the bit (follows out_ready) |
| in_bit | input | 1 | Scrambled line bit |
| out_valid | output | 1 | Descrambled bit is present |
| out_ready | input | 1 | Downstream accepts the bit |
| out_bit | output | 1 | Descrambled bit |
| out_word | output | WORD_W | Last WORD_W descrambled bits, newest in bit 0 |
| locked | output | 1 | Key is locked |
| abort_pulse | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
The bench keeps the default key width, check length, idle run length and word width, so lock timing is exact at 41 bits and can be checked to the cycle, including the late lock after a mismatch injected mid-check. It shrinks WD_CYCLES from 40000 to 400. This brings watchdog expiry, and the failure of nine-ones runs to clear it, within a few hundred bits. A 300-bit data frame still fits under the window without a false abort.

// File: rtl/ds_pkg.sv
package ds_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_CHECK  = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_t;
endpackage

// File: rtl/ds_keygen.sv
// Key stream register: follows the inverted line bit until locked,
// then free-runs on its own recurrence.
module ds_keygen #(
  parameter int KEY_W = 11,
  parameter int TAP   = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic follow_line,
  input  logic line_bit,
  output logic pred
);
  logic [KEY_W-1:0] st;
  logic             nxt;

  assign pred = st[KEY_W-1] ^ st[TAP-1];
  assign nxt  = follow_line ? ~line_bit : pred;

  always_ff @(posedge clk) begin
    if (rst)      st <= '0;
    else if (adv) st <= {st[KEY_W-2:0], nxt};
  end
endmodule

// File: rtl/ds_sync_fsm.sv
// Search / check / locked sequencing of the key acquisition.
module ds_sync_fsm
  import ds_pkg::*;
#(
  parameter int KEY_W     = 11,
  parameter int CHECK_LEN = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic line_key,
  input  logic pred,
  input  logic expire,
  output logic locked
);
  localparam int FILL_W  = $clog2(KEY_W + 1);
  localparam int MATCH_W = $clog2(CHECK_LEN + 1);
  localparam logic [FILL_W-1:0]  FILL_LAST  = FILL_W'(KEY_W - 1);
  localparam logic [MATCH_W-1:0] MATCH_LAST = MATCH_W'(CHECK_LEN - 1);

  sync_state_t         state;
  logic [FILL_W-1:0]   fill;
  logic [MATCH_W-1:0]  match;

  assign locked = (state == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SEARCH;
      fill  <= '0;
      match <= '0;
    end else if (expire) begin
      state <= ST_SEARCH;
      fill  <= '0;
    end else if (adv) begin
      case (state)
        ST_SEARCH: begin
          if (fill == FILL_LAST) begin
            state <= ST_CHECK;
            match <= '0;
          end else begin
            fill <= fill + 1'b1;
          end
        end
        ST_CHECK: begin
          if (line_key == pred) begin
            if (match == MATCH_LAST) state <= ST_LOCKED;
            else                     match <= match + 1'b1;
          end else begin
            state <= ST_SEARCH;
            fill  <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ds_idle_watch.sv
// Idle-run detector and loss-of-idle watchdog.
module ds_idle_watch #(
  parameter int RUN_LEN   = 10,
  parameter int WD_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic dbit,
  input  logic locked,
  output logic expire,
  output logic abort_pulse
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int WD_W  = $clog2(WD_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(WD_CYCLES - 1);

  logic [RUN_W-1:0] run;
  logic [WD_W-1:0]  wd;
  logic             hit;

  assign hit    = adv && dbit && (run == RUN_LAST);
  assign expire = locked && !hit && (wd == WD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run         <= '0;
      wd          <= '0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= expire;
      if (adv) begin
        if (!dbit)                run <= '0;
        else if (run != RUN_LAST) run <= run + 1'b1;
      end
      if (!locked || hit || wd == WD_LAST) wd <= '0;
      else                                 wd <= wd + 1'b1;
    end
  end
endmodule

// File: rtl/ds_sipo.sv
// Serial-to-parallel shifter of descrambled bits.
module ds_sipo #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              dbit,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)      word <= '0;
    else if (adv) word <= {word[WORD_W-2:0], dbit};
  end
endmodule

// File: rtl/stream_descrambler.sv
module stream_descrambler #(
  parameter int KEY_W     = 11,
  parameter int TAP       = 9,
  parameter int CHECK_LEN = 30,
  parameter int RUN_LEN   = 10,
  parameter int WD_CYCLES = 40000,
  parameter int WORD_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic [WORD_W-1:0] out_word,
  output logic              locked,
  output logic              abort_pulse
);
  logic adv;
  logic pred;
  logic expire;

  assign adv       = in_valid && out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_bit   = in_bit ^ pred;

  ds_keygen #(.KEY_W(KEY_W), .TAP(TAP)) u_key (
    .clk(clk), .rst(rst), .adv(adv), .follow_line(!locked),
    .line_bit(in_bit), .pred(pred)
  );

  ds_sync_fsm #(.KEY_W(KEY_W), .CHECK_LEN(CHECK_LEN)) u_sync (
    .clk(clk), .rst(rst), .adv(adv), .line_key(~in_bit), .pred(pred),
    .expire(expire), .locked(locked)
  );

  ds_idle_watch #(.RUN_LEN(RUN_LEN), .WD_CYCLES(WD_CYCLES)) u_watch (
    .clk(clk), .rst(rst), .adv(adv), .dbit(out_bit), .locked(locked),
    .expire(expire), .abort_pulse(abort_pulse)
  );

  ds_sipo #(.WORD_W(WORD_W)) u_sipo (
    .clk(clk), .rst(rst), .adv(adv), .dbit(out_bit), .word(out_word)
  );
endmodule

// File: rtl/ds_checker.sv
module ds_checker #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_ready,
  input logic              out_bit,
  input logic [WORD_W-1:0] out_word,
  input logic              locked,
  input logic              abort_pulse
);
  a_r8_abort_single: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |=> !abort_pulse);

  a_r8_abort_unlocks: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> !locked);

  a_r8_abort_from_lock: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> $past(locked));

  a_r4_lock_on_transfer: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(in_valid && out_ready));

  a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && out_ready) |=> $stable(out_word));

  a_r10_word_shift: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready) |=> out_word[0] == $past(out_bit));
endmodule

bind stream_descrambler ds_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
  .out_bit(out_bit), .out_word(out_word), .locked(locked),
  .abort_pulse(abort_pulse)
);

// File: tb/test_stream_descrambler.sv
`timescale 1ns/1ps
module test_stream_descrambler;
  localparam int KEY_W = 11, CHECK_LEN = 30, RUN_LEN = 10, WD = 400, WORD_W = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, locked, abort_pulse;
  logic [WORD_W-1:0] out_word;

  always #2 clk = ~clk;

  stream_descrambler #(.WD_CYCLES(WD)) i_stream_descrambler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_word(out_word), .locked(locked),
    .abort_pulse(abort_pulse)
  );

  int errors = 0, checks = 0, aborts = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit kh[$];                 // last KEY_W key bits, oldest first
  int m_st, m_fill, m_match, m_run, m_wd;
  bit m_abort;
  logic [WORD_W-1:0] m_word;
  bit p, x, d, hit, ex;

  function automatic bit m_pred();
    return kh[0] ^ kh[2];
  endfunction

  function automatic void m_reset();
    kh.delete();
    for (int i = 0; i < KEY_W; i++) kh.push_back(1'b0);
    m_st = 0; m_fill = 0; m_match = 0; m_run = 0; m_wd = 0;
    m_abort = 0; m_word = '0;
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (rst) m_reset();
    else begin
      p   = m_pred();
      x   = in_valid && out_ready;
      d   = in_bit ^ p;
      hit = x && d && (m_run == RUN_LEN - 1);
      ex  = (m_st == 2) && !hit && (m_wd == WD - 1);
      m_abort = ex;
      if (m_st != 2 || hit || m_wd == WD - 1) m_wd = 0;
      else m_wd++;
      if (x) begin
        m_run = d ? ((m_run == RUN_LEN - 1) ? m_run : m_run + 1) : 0;
        m_word = {m_word[WORD_W-2:0], d};
        kh.push_back((m_st == 2) ? p : ~in_bit);
        void'(kh.pop_front());
      end
      if (ex) begin
        m_st = 0; m_fill = 0;
      end else if (x) begin
        if (m_st == 0) begin
          if (m_fill == KEY_W - 1) begin m_st = 1; m_match = 0; end
          else m_fill++;
        end else if (m_st == 1) begin
          if (bit'(~in_bit) == p) begin
            if (m_match == CHECK_LEN - 1) m_st = 2;
            else m_match++;
          end else begin
            m_st = 0; m_fill = 0;
          end
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      chk(out_valid == in_valid, "R9", "out_valid", out_valid, in_valid);
      chk(in_ready == out_ready, "R9", "in_ready", in_ready, out_ready);
      if (in_valid) chk(out_bit == (in_bit ^ m_pred()), "R2", "out_bit", out_bit, in_bit ^ m_pred());
      chk(locked == (m_st == 2), "R4", "locked", locked, m_st == 2);
      chk(abort_pulse == m_abort, "R8", "abort_pulse", abort_pulse, m_abort);
      chk(out_word == m_word, "R10", "out_word", out_word, m_word);
      if (abort_pulse) aborts++;
    end
  end

  // ---------------- transmitter and stimulus ----------------
  logic [KEY_W-1:0] tk = 11'h5A3;

  task automatic push(bit plain, bit flip = 1'b0);
    bit k;
    @(negedge clk);
    k  = tk[10] ^ tk[8];
    tk = {tk[9:0], k};
    in_valid  = 1'b1;
    out_ready = 1'b1;
    in_bit    = plain ^ k ^ flip;
    #1;
    if (locked && !flip) chk(out_bit == plain, "R6", "descrambled bit", out_bit, plain);
  endtask

  task automatic gap(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bit   = 1'b0;
    end
    #1;
  endtask

  task automatic idles(int n);
    repeat (n) push(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [WORD_W-1:0] saved;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(locked == 0, "R1", "locked after reset", locked, 0);
    chk(abort_pulse == 0, "R1", "abort after reset", abort_pulse, 0);
    chk(out_word == 0, "R1", "word after reset", out_word, 0);

    // R3/R5: corrupt bit 20 (inside checking) delays lock
    idles(20);
    push(1'b1, 1'b1);
    idles(29);
    gap(1);
    chk(locked == 0, "R5", "no lock after mismatch", locked, 0);
    idles(11);
    gap(1);
    chk(locked == 0, "R4", "lock one bit early", locked, 0);
    idles(1);
    gap(1);
    chk(locked == 1, "R4", "lock after 41 fresh bits (R3)", locked, 1);

    // R6/R7: data frame under the window
    idles(20);
    aborts = 0;
    repeat (300) push(1'($urandom_range(0, 1)));
    idles(30);
    gap(1);
    chk(aborts == 0, "R7", "no abort within frame", aborts, 0);
    chk(locked == 1, "R7", "lock held across frame", locked, 1);

    // R9: back-pressure
    saved = out_word;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b0; in_bit = i[0];
      #1;
      chk(in_ready == 0, "R9", "in_ready under stall", in_ready, 0);
    end
    gap(1);
    chk(out_word == saved, "R9", "word held under stall", out_word, saved);
    idles(20);

    // R10/R6: transfers with valid gaps
    for (int i = 0; i < 40; i++) begin
      push(1'(i % 3 == 0));
      gap(1);
    end
    idles(20);

    // R7/R8: nine-ones runs never clear the watchdog
    aborts = 0;
    repeat (45) begin
      repeat (9) push(1'b1);
      push(1'b0);
    end
    gap(2);
    chk(aborts == 1, "R8", "single abort pulse (R7)", aborts, 1);
    chk(locked == 0, "R8", "unlocked after abort", locked, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule